// File: doc/BRIEF.md
# Hot-Swap Power-Up Sequencer

This block brings up a hot-swapped slot in a fixed order. It first waits for the slot to be seated and for both supply-voltage windows to report good. It then holds the pass-transistor gate drive off for a programmable settling delay. Once the gate is driven, it allows only a bounded time in current regulation. After the transistor reports fully on, it releases two power-up enables one after the other. Each enable has its own programmable delay, and the second is also gated by the feedback input.

Every delay is chosen by a 4-bit code. The code selects one of sixteen fixed durations, from a quarter millisecond up to three quarters of a second. A prescaler turns the system clock into a 0.25 ms tick, and all durations are counted in these ticks. The four codes are packed into two byte-wide configuration registers, which are written through a small synchronous write port.

Top module: `hs_pwrup_seq`

## Requirements
- R1: After synchronous reset all four outputs are low. Both configuration registers read 0x88, so every timer code is 1000 (64 ms).
- R2: Timer code c selects the following number of 0.25 ms ticks, for c = 0 to 15: 1, 8, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024, 1536, 2048, 3072. A tick lasts TICK_DIV clock cycles.
- R3: Call E the first rising edge at which `pin_det`, `uv_good` and `ov_good` are all high. The gate-delay code is register 0 bits [3:0], and it gives N ticks. `gate_drv` stays low until edge E + N·TICK_DIV + 1, and it is high from that edge on.
- R4: When the gate drive turns on, the regulation timer starts with the code in register 0 bits [7:4]. If `i_reg_active` is high when this timer has expired, `seq_fault` goes high and `gate_drv`, `pup_en1` and `pup_en2` go low.
- R5: During the regulation phase, the first edge that sees `fet_full_on` high and `i_reg_active` low starts slot 0, using register 1 bits [3:0]. `pup_en1` rises N·TICK_DIV + 1 edges later.
- R6: After `pup_en1` is high, the first edge that sees `fb_good` high starts slot 1, using register 1 bits [7:4]. `pup_en2` rises N·TICK_DIV + 1 edges later. `pup_en2` is never high without `pup_en1`.
- R7: If any of `pin_det`, `uv_good` or `ov_good` is low at an edge outside the fault state, all outputs are low after that edge, and the sequence restarts from the beginning.
- R8: `seq_fault` stays high while `pin_det` stays high, whatever the voltage inputs do. It is cleared by reset or by `pin_det` going low, and a new sequence can then start.
- R9: A configuration write while a timer runs leaves that timer's duration unchanged. The new code is used at the next timer start.
- R10: A write with `cfg_we` high stores `cfg_wdata` into register 0 when `cfg_addr` is 0 and into register 1 when it is 1. The other register is left unchanged.
- R11: Once the regulation phase has ended, `i_reg_active` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| pin_det | input | 1 | Slot seated / pin detect enabled |
| uv_good | input | 1 | Undervoltage check passes |
| ov_good | input | 1 | Overvoltage check passes |
| fet_full_on | input | 1 | Pass transistor fully enhanced |
| i_reg_active | input | 1 | Current regulation loop is active |
| fb_good | input | 1 | Feedback input high |
| gate_drv | output | 1 | Gate drive enable |
| pup_en1 | output | 1 | First power-up enable |
| pup_en2 | output | 1 | Second power-up enable |
| seq_fault | output | 1 | Latched regulation fault |

## Verification
The gate delay is swept across all sixteen codes, which separates every entry of the duration table from its neighbours and shows an off-by-one in the prescaler or the counter. Full sequences are run with different codes for the two slots, and with a late feedback input, to tell the two slot fields apart and to show that each slot starts from its own trigger. Sequences that hold regulation past the timer, that drop one voltage input at a time, and that rewrite a code while its timer runs separate the fault latch, the abort path and the latch-on-start rule from a plain timer.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    localparam int TICK_W   = 12;
    localparam int CODE_W   = 4;
    localparam int NUM_CFG  = 2;
    localparam int CFG_AW   = $clog2(NUM_CFG);
    localparam logic [CODE_W-1:0] CODE_DEFAULT = 4'b1000;

    typedef logic [TICK_W-1:0] tick_cnt_t;

    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
    } cfg_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDLY,
        ST_RAMP,
        ST_SLOT0,
        ST_WAITFB,
        ST_SLOT1,
        ST_ON,
        ST_FAULT
    } seq_state_e;

    // Duration in 0.25 ms ticks for each 4-bit timer code.
    function automatic tick_cnt_t code_ticks(input logic [CODE_W-1:0] code);
        tick_cnt_t t;
        case (code)
            4'd0:    t = 12'd1;
            4'd1:    t = 12'd8;
            4'd2:    t = 12'd32;
            4'd3:    t = 12'd48;
            4'd4:    t = 12'd64;
            4'd5:    t = 12'd96;
            4'd6:    t = 12'd128;
            4'd7:    t = 12'd192;
            4'd8:    t = 12'd256;
            4'd9:    t = 12'd384;
            4'd10:   t = 12'd512;
            4'd11:   t = 12'd768;
            4'd12:   t = 12'd1024;
            4'd13:   t = 12'd1536;
            4'd14:   t = 12'd2048;
            default: t = 12'd3072;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/hs_seq_prescale.sv
module hs_seq_prescale #(
    parameter int TICK_DIV = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hs_seq_timer.sv
module hs_seq_timer
    import hs_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              tick,
    output logic              expired
);
    logic      running_q;
    tick_cnt_t remain_q;

    assign expired = running_q && (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            remain_q  <= '0;
        end else if (start) begin
            running_q <= 1'b1;
            remain_q  <= code_ticks(code);
        end else if (tick && running_q && (remain_q != '0)) begin
            remain_q  <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/hs_seq_cfg.sv
module hs_seq_cfg
    import hs_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output cfg_byte_t         regs_o [NUM_CFG]
);
    localparam cfg_byte_t CFG_RESET = '{hi: CODE_DEFAULT, lo: CODE_DEFAULT};

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[i] <= CFG_RESET;
            end else if (wr_en && (wr_addr == CFG_AW'(i))) begin
                regs_o[i] <= cfg_byte_t'(wr_data);
            end
        end
    end
endmodule

// File: rtl/hs_pwrup_seq.sv
module hs_pwrup_seq
    import hs_seq_pkg::*;
#(
    parameter int TICK_DIV = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       pin_det,
    input  logic       uv_good,
    input  logic       ov_good,
    input  logic       fet_full_on,
    input  logic       i_reg_active,
    input  logic       fb_good,
    output logic       gate_drv,
    output logic       pup_en1,
    output logic       pup_en2,
    output logic       seq_fault
);
    seq_state_e        st_q, st_d;
    cfg_byte_t         cfg [NUM_CFG];
    logic              tick, expired, t_start, all_ok;
    logic [CODE_W-1:0] t_code;

    hs_seq_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .regs_o  (cfg)
    );

    hs_seq_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (t_start),
        .tick (tick)
    );

    hs_seq_timer u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (t_start),
        .code    (t_code),
        .tick    (tick),
        .expired (expired)
    );

    assign all_ok = pin_det && uv_good && ov_good;

    always_comb begin
        st_d    = st_q;
        t_start = 1'b0;
        t_code  = cfg[0].lo;
        case (st_q)
            ST_IDLE: if (all_ok) begin
                st_d = ST_PDLY; t_start = 1'b1; t_code = cfg[0].lo;
            end
            ST_PDLY: if (expired) begin
                st_d = ST_RAMP; t_start = 1'b1; t_code = cfg[0].hi;
            end
            ST_RAMP: begin
                if (fet_full_on && !i_reg_active) begin
                    st_d = ST_SLOT0; t_start = 1'b1; t_code = cfg[1].lo;
                end else if (expired && i_reg_active) begin
                    st_d = ST_FAULT;
                end
            end
            ST_SLOT0:  if (expired) st_d = ST_WAITFB;
            ST_WAITFB: if (fb_good) begin
                st_d = ST_SLOT1; t_start = 1'b1; t_code = cfg[1].hi;
            end
            ST_SLOT1:  if (expired) st_d = ST_ON;
            ST_ON:     st_d = ST_ON;
            ST_FAULT:  if (!pin_det) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
        if (!all_ok && (st_q != ST_IDLE) && (st_q != ST_FAULT)) begin
            st_d    = ST_IDLE;
            t_start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        gate_drv  = 1'b0;
        pup_en1   = 1'b0;
        pup_en2   = 1'b0;
        seq_fault = (st_q == ST_FAULT);
        case (st_q)
            ST_RAMP, ST_SLOT0:  gate_drv = 1'b1;
            ST_WAITFB, ST_SLOT1: begin gate_drv = 1'b1; pup_en1 = 1'b1; end
            ST_ON: begin gate_drv = 1'b1; pup_en1 = 1'b1; pup_en2 = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/hs_pwrup_seq_chk.sv
module hs_pwrup_seq_chk (
    input logic clk,
    input logic rst,
    input logic pin_det,
    input logic uv_good,
    input logic ov_good,
    input logic gate_drv,
    input logic pup_en1,
    input logic pup_en2,
    input logic seq_fault
);
    logic ok;
    assign ok = pin_det && uv_good && ov_good;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!gate_drv && !pup_en1 && !pup_en2 && !seq_fault)); // R1
    AST_GATE_AFTER_OK: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_drv) |-> $past(ok)); // R3
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
        seq_fault |-> (!gate_drv && !pup_en1 && !pup_en2)); // R4
    AST_PUP1_GATED: assert property (@(posedge clk) disable iff (rst)
        pup_en1 |-> gate_drv); // R5
    AST_PUP_ORDER: assert property (@(posedge clk) disable iff (rst)
        pup_en2 |-> pup_en1); // R6
    AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (rst)
        !ok |=> !gate_drv); // R7
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seq_fault && pin_det) |=> seq_fault); // R8
endmodule

bind hs_pwrup_seq hs_pwrup_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_det   (pin_det),
    .uv_good   (uv_good),
    .ov_good   (ov_good),
    .gate_drv  (gate_drv),
    .pup_en1   (pup_en1),
    .pup_en2   (pup_en2),
    .seq_fault (seq_fault)
);

// File: tb/hs_pwrup_seq_tb.sv
module hs_pwrup_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic pin_det = 0, uv_good = 0, ov_good = 0, fet_full_on = 0, i_reg_active = 0, fb_good = 0;
    logic gate_drv, pup_en1, pup_en2, seq_fault;

    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_pwrup_seq #(.TICK_DIV(P)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pin_det(pin_det), .uv_good(uv_good), .ov_good(ov_good), .fet_full_on(fet_full_on),
        .i_reg_active(i_reg_active), .fb_good(fb_good), .gate_drv(gate_drv),
        .pup_en1(pup_en1), .pup_en2(pup_en2), .seq_fault(seq_fault)
    );

    function automatic int ticks_of(input int c);
        int t [16] = '{1, 8, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024, 1536, 2048, 3072};
        return t[c];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase number, cycle counter, duration, config bytes.
    int m_ph = 0, m_cnt = 0, m_dur = 0;
    bit m_run = 0;
    int m_r0 = 8'h88, m_r1 = 8'h88;

    always @(posedge clk) begin
        bit ok, exp_now, go;
        int code;
        if (rst) begin
            m_ph = 0; m_run = 0; m_cnt = 0; m_dur = 0; m_r0 = 8'h88; m_r1 = 8'h88;
        end else begin
            ok = pin_det && uv_good && ov_good;
            exp_now = m_run && (m_cnt == m_dur);
            if (m_run && !exp_now) m_cnt++;
            go = 0; code = 0;
            if (m_ph != 0 && m_ph != 7 && !ok) m_ph = 0;
            else case (m_ph)
                0: if (ok) begin m_ph = 1; go = 1; code = m_r0 & 15; end
                1: if (exp_now) begin m_ph = 2; go = 1; code = m_r0 >> 4; end
                2: if (fet_full_on && !i_reg_active) begin m_ph = 3; go = 1; code = m_r1 & 15; end
                   else if (exp_now && i_reg_active) m_ph = 7;
                3: if (exp_now) m_ph = 4;
                4: if (fb_good) begin m_ph = 5; go = 1; code = m_r1 >> 4; end
                5: if (exp_now) m_ph = 6;
                7: if (!pin_det) m_ph = 0;
                default: ;
            endcase
            if (go) begin m_run = 1; m_cnt = 0; m_dur = ticks_of(code) * P; end
            if (cfg_we) begin
                if (cfg_addr) m_r1 = cfg_wdata; else m_r0 = cfg_wdata;
            end
        end
    end

    always @(negedge clk) begin
        check("gate_drv R3 R4 R7", gate_drv, (m_ph >= 2 && m_ph <= 6) ? 1 : 0);
        check("pup_en1 R5 R7", pup_en1, (m_ph >= 4 && m_ph <= 6) ? 1 : 0);
        check("pup_en2 R6 R11", pup_en2, (m_ph == 6) ? 1 : 0);
        check("seq_fault R4 R8", seq_fault, (m_ph == 7) ? 1 : 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input bit a, input int d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_ok(input bit v);
        pin_det = v; uv_good = v; ov_good = v;
    endtask

    // which: 0 gate, 1 pup1, 2 pup2, 3 fault
    task automatic measure(input int which, output int n);
        bit s;
        n = 0;
        do begin
            @(negedge clk); n++;
            case (which)
                0: s = gate_drv; 1: s = pup_en1; 2: s = pup_en2; default: s = seq_fault;
            endcase
        end while (!s && n < 20000);
    endtask

    task automatic idle_out();
        set_ok(0); fet_full_on = 0; i_reg_active = 0; fb_good = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 gate after reset", gate_drv, 0);
        check("R1 fault after reset", seq_fault, 0);
        // R1: default gate delay code 1000 = 256 ticks
        set_ok(1); measure(0, n);
        check("R1 R3 default delay", n, 256 * P + 2);
        idle_out();

        // R2: sweep all codes on the gate delay
        for (int c = 0; c < 16; c++) begin
            wr(0, c);
            set_ok(1); measure(0, n);
            check($sformatf("R2 R3 code %0d", c), n, ticks_of(c) * P + 2);
            idle_out();
        end

        // R10 R5 R6: distinct slot codes, late feedback
        wr(0, 8'h00); wr(1, 8'h31);
        set_ok(1); measure(0, n);
        fet_full_on = 1; measure(1, n);
        check("R5 R10 slot0 code 1", n, 8 * P + 2);
        repeat (5) @(negedge clk);
        check("R6 pup2 waits for fb", pup_en2, 0);
        fb_good = 1; measure(2, n);
        check("R6 R10 slot1 code 3", n, 48 * P + 2);
        // R11: regulation input ignored once running
        i_reg_active = 1; repeat (20) @(negedge clk);
        check("R11 pup2 kept", pup_en2, 1);
        check("R11 no fault", seq_fault, 0);
        i_reg_active = 0;
        // R7: one voltage input lost
        ov_good = 0; @(negedge clk);
        check("R7 gate dropped", gate_drv, 0);
        check("R7 pup1 dropped", pup_en1, 0);
        idle_out();

        // R4 R8: regulation held past timer
        wr(0, 8'h20); i_reg_active = 1;
        set_ok(1); measure(0, n); measure(3, n);
        check("R4 fault after 32 ticks", n, 32 * P + 1);
        check("R4 gate off", gate_drv, 0);
        uv_good = 0; repeat (4) @(negedge clk); uv_good = 1;
        repeat (4) @(negedge clk);
        check("R8 fault held", seq_fault, 1);
        pin_det = 0; @(negedge clk);
        check("R8 fault cleared", seq_fault, 0);
        i_reg_active = 0; pin_det = 1; measure(0, n);
        check("R8 restart", n, 1 * P + 2);
        idle_out();

        // R9: rewrite gate code while its timer runs
        wr(0, 8'h05); set_ok(1); n = 0;
        while (!gate_drv && n < 5000) begin
            @(negedge clk); n++;
            if (n == 20) begin cfg_we = 1; cfg_addr = 0; cfg_wdata = 8'h00; end
            else if (n == 21) cfg_we = 0;
        end
        check("R9 running timer kept", n, 96 * P + 2);
        idle_out();
        set_ok(1); measure(0, n);
        check("R9 new code next start", n, 1 * P + 2);
        idle_out();

        // R1 via reset: registers back to 0x88
        rst = 1; repeat (2) @(negedge clk); rst = 0;
        set_ok(1); measure(0, n);
        fet_full_on = 1; measure(1, n);
        check("R1 slot0 default", n, 256 * P + 2);
        idle_out();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule